// File: doc/BRIEF.md
# Banked Memory Map Controller with Color Decode

This block turns a 16-bit CPU address into a physical memory address for a small machine that has one ROM image and three 64 KB RAM pages. An 8-bit map register splits the CPU space into four regions of unequal size. Each region has a 2-bit field in that register. The field points its region either at write-protected ROM or at one of the three RAM pages. The block drives the physical address and the ROM, RAM and peripheral selects. It also drives the memory write strobe, and it muxes the read data back to the CPU.

When the top region is in ROM mode, it is split into three parts. Its lowest part still reads ROM. The next 2 KB is an empty hole that reads as all ones. The upper 2 KB becomes a window onto a four-register parallel port, and that window repeats every four bytes. A second 8-bit register holds the display colors: two 3-bit foreground indexes and a 3-bit background index. The background index is assembled from the two top bits of that register. Software can read back both registers.

Top module: `mmc_bank_ctrl`

## Requirements
- R1: The map register fields govern these regions: bits [1:0] cover 0x0000-0x3FFF, bits [3:2] cover 0x4000-0x8FFF, bits [5:4] cover 0x9000-0xBFFF, and bits [7:6] cover 0xC000-0xFFFF.
- R2: A field value v of 1, 2 or 3 selects RAM.
  - `phys_addr` is (v-1)·0x10000 plus the CPU address.
  - `ram_sel` is high.
  - `mem_we` follows `cpu_wr`.
- R3: A field value of 0 selects ROM.
  - `phys_addr` is 0x10000 plus the CPU address.
  - `rom_sel` is high.
  - `mem_we` stays low for a write, so the write is discarded.
- R4: When the top field is 0, an access to 0xF000-0xF7FF raises `float_sel`, returns 0xFF on `cpu_rdata`, and leaves `rom_sel`, `ram_sel`, `mem_we` and `port_cs` low.
- R5: When the top field is 0, an access to 0xF800-0xFFFF raises `port_cs`.
  - `port_reg` equals CPU address bits [1:0], so the port repeats every four bytes.
  - `port_we` follows `cpu_wr`.
  - `cpu_rdata` carries `port_rdata`.
- R6: After reset both registers read 0x00, so every region starts in ROM mode.
- R7: `reg_rdata` returns the map register when `reg_sel`=0 and the color register when `reg_sel`=1.
- R8: Color decode: `fg_a` is bits [2:0] of the color register, `fg_b` is bits [5:3], and `bg_idx` is bit 6 plus 4 × bit 7.
- R9: A register write is captured at the clock edge. An access in the same cycle as the write is decoded with the old map. Accesses from the next cycle onward use the new map.
- R10: For a ROM or RAM access, `cpu_rdata` equals `mem_rdata`.
- R11: While `cpu_req` is low, these outputs stay low: `rom_sel`, `ram_sel`, `port_cs`, `float_sel`, `mem_we` and `port_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = map register, 1 = color register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back |
| cpu_req | input | 1 | CPU memory access valid |
| cpu_wr | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU address |
| mem_rdata | input | 8 | Read data from ROM/RAM |
| port_rdata | input | 8 | Read data from the parallel port |
| phys_addr | output | 18 | Physical ROM/RAM address |
| rom_sel | output | 1 | ROM selected |
| ram_sel | output | 1 | RAM selected |
| mem_we | output | 1 | Memory write enable |
| port_cs | output | 1 | Parallel port chip select |
| port_we | output | 1 | Parallel port write |
| port_reg | output | 2 | Parallel port register index |
| float_sel | output | 1 | Access falls in the open-bus hole |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| fg_a | output | 3 | Foreground color 1 |
| fg_b | output | 3 | Foreground color 2 |
| bg_idx | output | 3 | Background color index |

## Verification
A map-register write and a CPU access can land in the same clock cycle. The decode then has to use the map that was in force before the edge. The bench starts from an all-ROM map and, in a single cycle, issues a write that turns every field into RAM page 2 together with a CPU write to 0x0100. Before the edge it expects ROM select with no write strobe. After the edge it expects RAM page 2 with the write strobe raised. Every one of the 256 map values is also swept over region boundary addresses for both reads and writes, and each result is compared with a map computed arithmetically in the bench.

// File: rtl/mmc_pkg.sv
// Package: shared constants, types and region lookup for the memory map
// controller. Assumes a 16-bit CPU space split at fixed boundaries.
package mmc_pkg;

    localparam int CPU_AW    = 16;
    localparam int DW        = 8;
    localparam int FIELD_W   = 2;
    localparam int N_REGION  = 4;
    localparam int PHYS_AW   = CPU_AW + FIELD_W;
    localparam int PORT_IW   = 2;

    localparam logic [CPU_AW-1:0] BASE_R1    = 16'h4000;
    localparam logic [CPU_AW-1:0] BASE_R2    = 16'h9000;
    localparam logic [CPU_AW-1:0] BASE_R3    = 16'hC000;
    localparam logic [CPU_AW-1:0] HOLE_BASE  = 16'hF000;
    localparam logic [CPU_AW-1:0] PORT_BASE  = 16'hF800;

    localparam logic [FIELD_W-1:0] ROM_PAGE  = 2'd1;
    localparam logic [FIELD_W-1:0] FIELD_ROM = 2'd0;
    localparam logic [DW-1:0]      FLOAT_VAL = 8'hFF;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_ROM   = 3'd1,
        TGT_RAM   = 3'd2,
        TGT_PORT  = 3'd3,
        TGT_FLOAT = 3'd4
    } tgt_e;

    // Returns the region index an address falls in
    function automatic logic [1:0] region_of(input logic [CPU_AW-1:0] a);
        if (a < BASE_R1)      return 2'd0;
        else if (a < BASE_R2) return 2'd1;
        else if (a < BASE_R3) return 2'd2;
        else                  return 2'd3;
    endfunction

endpackage

// File: rtl/mmc_cfg_regs.sv
// Module: map and color registers with read-back and color decode.
// Assumes a single write port; the decoded colors are combinational.
module mmc_cfg_regs
    import mmc_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int COL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] map_q,
    output logic [COL_W-1:0]  col_a,
    output logic [COL_W-1:0]  col_b,
    output logic [COL_W-1:0]  col_bg
);

    logic [DATA_W-1:0] map_r;
    logic [DATA_W-1:0] col_r;

    // Register update: reset clears both, a write loads the selected one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_r <= '0;
            col_r <= '0;
        end else if (wr_en) begin
            if (sel) col_r <= wdata;
            else     map_r <= wdata;
        end
    end

    // Read-back mux and color field extraction
    always_comb begin
        rdata  = sel ? col_r : map_r;
        map_q  = map_r;
        col_a  = col_r[COL_W-1:0];
        col_b  = col_r[2*COL_W-1:COL_W];
        col_bg = {col_r[DATA_W-1], 1'b0, col_r[DATA_W-2]};
    end

    p_map_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !sel) |=> $stable(map_r));
    p_col_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel) |=> $stable(col_r));
    p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (map_r == '0 && col_r == '0));

endmodule

// File: rtl/mmc_field_map.sv
// Module: translates one region's 2-bit field into a physical address.
// Assumes field 0 means ROM and values 1..3 mean RAM pages 0..2.
module mmc_field_map
    import mmc_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int FW = FIELD_W
) (
    input  logic [FW-1:0]    field,
    input  logic [AW-1:0]    addr,
    output logic             is_ram,
    output logic [AW+FW-1:0] phys
);

    // Page arithmetic: ROM sits at a fixed page, RAM at field minus one
    always_comb begin
        is_ram = (field != FIELD_ROM);
        if (is_ram) phys = {field - FW'(1), addr};
        else        phys = {ROM_PAGE, addr};
    end

endmodule

// File: rtl/mmc_addr_router.sv
// Module: picks the region for a CPU address, runs one field decoder per
// region, and carves the top region into ROM, hole and port window when
// its field is 0. Assumes the map value is stable during the access.
module mmc_addr_router
    import mmc_pkg::*;
#(
    parameter int AW  = CPU_AW,
    parameter int FW  = FIELD_W,
    parameter int NR  = N_REGION,
    parameter int MW  = FW * NR
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [MW-1:0]  map_q,
    input  logic           req,
    input  logic [AW-1:0]  addr,
    output tgt_e           tgt,
    output logic [AW+FW-1:0] phys
);

    localparam int PW = AW + FW;

    logic [NR-1:0]  ram_v;
    logic [PW-1:0]  phys_v [NR];
    logic [1:0]     ridx;

    // One decoder per region field
    for (genvar g = 0; g < NR; g++) begin : g_field
        mmc_field_map #(.AW(AW), .FW(FW)) u_fm (
            .field  (map_q[g*FW +: FW]),
            .addr   (addr),
            .is_ram (ram_v[g]),
            .phys   (phys_v[g])
        );
    end

    // Target selection including the top-region peripheral carve-out
    always_comb begin
        ridx = region_of(addr);
        phys = phys_v[ridx];
        if (!req) begin
            tgt = TGT_NONE;
        end else if (ram_v[ridx]) begin
            tgt = TGT_RAM;
        end else if (ridx == 2'd3 && addr >= PORT_BASE) begin
            tgt = TGT_PORT;
        end else if (ridx == 2'd3 && addr >= HOLE_BASE) begin
            tgt = TGT_FLOAT;
        end else begin
            tgt = TGT_ROM;
        end
    end

    p_port_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_PORT) |-> (map_q[MW-1 -: FW] == FIELD_ROM && addr[AW-1 -: 5] == 5'h1F));
    p_hole_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_FLOAT) |-> (map_q[MW-1 -: FW] == FIELD_ROM && addr[AW-1 -: 5] == 5'h1E));
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (tgt == TGT_NONE));

endmodule

// File: rtl/mmc_bank_ctrl.sv
// Module: top of the memory map controller. Combines the register file,
// the address router and the strobe/read-data generation.
// Assumes ROM/RAM and port read data are valid in the access cycle.
module mmc_bank_ctrl
    import mmc_pkg::*;
#(
    parameter int AW     = CPU_AW,
    parameter int DATA_W = DW,
    parameter int FW     = FIELD_W,
    parameter int PIW    = PORT_IW,
    parameter int COL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] port_rdata,
    output logic [AW+FW-1:0]  phys_addr,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              mem_we,
    output logic              port_cs,
    output logic              port_we,
    output logic [PIW-1:0]    port_reg,
    output logic              float_sel,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [COL_W-1:0]  fg_a,
    output logic [COL_W-1:0]  fg_b,
    output logic [COL_W-1:0]  bg_idx
);

    logic [DATA_W-1:0] map_q;
    tgt_e              tgt;

    mmc_cfg_regs #(.DATA_W(DATA_W), .COL_W(COL_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .map_q  (map_q),
        .col_a  (fg_a),
        .col_b  (fg_b),
        .col_bg (bg_idx)
    );

    mmc_addr_router #(.AW(AW), .FW(FW), .NR(DATA_W / FW)) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .map_q (map_q),
        .req   (cpu_req),
        .addr  (cpu_addr),
        .tgt   (tgt),
        .phys  (phys_addr)
    );

    // Select lines, write strobes and read-data return
    always_comb begin
        rom_sel   = (tgt == TGT_ROM);
        ram_sel   = (tgt == TGT_RAM);
        port_cs   = (tgt == TGT_PORT);
        float_sel = (tgt == TGT_FLOAT);
        mem_we    = ram_sel && cpu_wr;
        port_we   = port_cs && cpu_wr;
        port_reg  = cpu_addr[PIW-1:0];
        case (tgt)
            TGT_ROM, TGT_RAM: cpu_rdata = mem_rdata;
            TGT_PORT:         cpu_rdata = port_rdata;
            default:          cpu_rdata = FLOAT_VAL;
        endcase
    end

    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel, port_cs, float_sel}));
    p_rom_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> !mem_we);
    p_float_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        float_sel |-> (cpu_rdata == FLOAT_VAL && !mem_we && !port_we));
    p_mem_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel || ram_sel) |-> (cpu_rdata == mem_rdata));

endmodule

// File: tb/mmc_bank_ctrl_test.sv
`timescale 1ns/1ps
module mmc_bank_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic        cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  mem_rdata = 8'hA5, port_rdata = 8'h3C;
    logic [17:0] phys_addr;
    logic        rom_sel, ram_sel, mem_we, port_cs, port_we, float_sel;
    logic [1:0]  port_reg;
    logic [7:0]  cpu_rdata;
    logic [2:0]  fg_a, fg_b, bg_idx;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    mmc_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_req(cpu_req),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .mem_rdata(mem_rdata),
        .port_rdata(port_rdata), .phys_addr(phys_addr), .rom_sel(rom_sel),
        .ram_sel(ram_sel), .mem_we(mem_we), .port_cs(port_cs),
        .port_we(port_we), .port_reg(port_reg), .float_sel(float_sel),
        .cpu_rdata(cpu_rdata), .fg_a(fg_a), .fg_b(fg_b), .bg_idx(bg_idx)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input bit s, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Outputs packed {rom,ram,port,float,mem_we,port_we,port_reg,rdata}
    function automatic logic [15:0] pack_out();
        return {rom_sel, ram_sel, port_cs, float_sel, mem_we, port_we, port_reg, cpu_rdata};
    endfunction

    // Independent model of the map, returns packed expectation and phys
    task automatic model(input logic [7:0] rr, input logic [15:0] a, input bit w,
                         output logic [15:0] exp, output logic [17:0] ph, output string tag);
        int r, f;
        // R1: region boundaries and field positions
        r = (a < 16'h4000) ? 0 : (a < 16'h9000) ? 1 : (a < 16'hC000) ? 2 : 3;
        f = (rr >> (2 * r)) & 3;
        ph = 18'(((f == 0) ? 32'h10000 : (f - 1) * 32'h10000) + a);
        if (f != 0) begin
            exp = {1'b0, 1'b1, 1'b0, 1'b0, w, 1'b0, a[1:0], mem_rdata}; tag = "R1 R2";
        end else if (r == 3 && a >= 16'hF800) begin
            exp = {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, w, a[1:0], port_rdata}; tag = "R5";
        end else if (r == 3 && a >= 16'hF000) begin
            exp = {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a[1:0], 8'hFF}; tag = "R4";
        end else begin
            exp = {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, a[1:0], mem_rdata}; tag = "R1 R3 R10";
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    initial begin
        logic [15:0] addrs [13];
        logic [15:0] e;
        logic [17:0] ph;
        string tag;
        addrs = '{16'h0000, 16'h3FFF, 16'h4000, 16'h8FFF, 16'h9000, 16'hBFFF,
                  16'hC000, 16'hEFFF, 16'hF000, 16'hF7FF, 16'hF800, 16'hFFFF, 16'hF806};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        reg_sel = 1'b0; #1;
        chk(reg_rdata == 8'h00, "R6 map", reg_rdata, 8'h00);
        reg_sel = 1'b1; #1;
        chk(reg_rdata == 8'h00, "R6 color", reg_rdata, 8'h00);
        cpu_req = 1'b1; cpu_addr = 16'h1234; cpu_wr = 1'b1; #1;
        chk(rom_sel && !mem_we, "R6 rom at reset", {rom_sel, mem_we}, 2'b10);
        cpu_req = 1'b0; #1;
        // R11: idle outputs
        chk({rom_sel, ram_sel, port_cs, float_sel, mem_we, port_we} == 6'b0, "R11",
            {rom_sel, ram_sel, port_cs, float_sel, mem_we, port_we}, 0);

        // Map sweep: every register value, boundary addresses, read and write
        for (int v = 0; v < 256; v++) begin
            wr_reg(1'b0, 8'(v));
            reg_sel = 1'b0; #1;
            chk(reg_rdata == 8'(v), "R7 map", reg_rdata, v);
            for (int i = 0; i < 13; i++) begin
                for (int w = 0; w < 2; w++) begin
                    cpu_req = 1'b1; cpu_addr = addrs[i]; cpu_wr = w[0];
                    mem_rdata = 8'(v ^ i); port_rdata = 8'(8'h3C + i);
                    #1;
                    model(8'(v), addrs[i], w[0], e, ph, tag);
                    chk(pack_out() == e, tag, pack_out(), e);
                    if (rom_sel || ram_sel)
                        chk(phys_addr == ph, tag, phys_addr, ph);
                end
            end
            cpu_req = 1'b0; #1;
            chk({rom_sel, ram_sel, port_cs, float_sel} == 4'b0, "R11", {rom_sel, ram_sel, port_cs, float_sel}, 0);
        end

        // Color sweep
        for (int v = 0; v < 256; v++) begin
            wr_reg(1'b1, 8'(v));
            reg_sel = 1'b1; #1;
            chk(reg_rdata == 8'(v), "R7 color", reg_rdata, v);
            chk(fg_a == 3'(v % 8), "R8 fg_a", fg_a, v % 8);
            chk(fg_b == 3'((v / 8) % 8), "R8 fg_b", fg_b, (v / 8) % 8);
            chk(bg_idx == 3'(((v >> 6) & 1) + 4 * ((v >> 7) & 1)), "R8 bg", bg_idx,
                ((v >> 6) & 1) + 4 * ((v >> 7) & 1));
        end

        // R9: register write and CPU access in the same cycle
        wr_reg(1'b0, 8'h00);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hFF;
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 16'h0100;
        #1;
        chk(rom_sel && !mem_we && phys_addr == 18'h10100, "R9 old map",
            {rom_sel, mem_we, phys_addr}, {1'b1, 1'b0, 18'h10100});
        @(negedge clk);
        reg_wr_en = 1'b0; #1;
        chk(ram_sel && mem_we && phys_addr == 18'h20100, "R9 new map",
            {ram_sel, mem_we, phys_addr}, {1'b1, 1'b1, 18'h20100});
        cpu_req = 1'b0;

        // R6: reset again clears both registers
        wr_reg(1'b1, 8'h5A);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_sel = 1'b0; #1;
        chk(reg_rdata == 8'h00, "R6 map re-reset", reg_rdata, 0);
        reg_sel = 1'b1; #1;
        chk(reg_rdata == 8'h00, "R6 color re-reset", reg_rdata, 0);
        finish_up();
    end

endmodule